// File: doc/BRIEF.md
# SPI Flash Word-Packing Transfer Engine

This block is the serial datapath and sequencer of a SPI flash master whose software side moves 32-bit words. Software queues transmit words by writing one of four aliased offsets; which offset was written tells the engine how many of the word's bytes are valid (one to four). The engine sends those bytes on MOSI in single-lane SPI mode, lowest byte of the word first and each byte most significant bit first. It collects one MISO byte for every byte it sends and packs them into one receive word per transmit word, which it places in an internal receive queue.

A configuration word sets master mode, clock polarity, clock phase, a power-of-two SCLK divider and a software-controlled chip select. A separate enable register gates the start of new words. Two single-cycle event outputs report a transmit queue that ran dry while chip select was held by software, and a receive word lost because the receive queue was full.

Top module: `sfq_engine`

## Requirements
- R1: A write to offset 0x1C queues a word with 4 valid bytes; writes to 0x80, 0x84 and 0x88 queue words with 1, 2 and 3 valid bytes. Byte 0 (bits 7:0) is sent first, each byte MSB first on MOSI, and the unused upper bytes of a short word are never sent.
- R2: The receive word for n valid bytes holds the k-th received byte in bits 8(k+4−n)+7 down to 8(k+4−n); for n = 4 byte k sits in bits 8k+7:8k, and for n < 4 all bits below 32−8n are zero.
- R3: With the divider field x in configuration bits 5:3, SCLK runs with a period of 2<<x reference clocks (half period 2^x).
- R4: SCLK rests at the polarity level from configuration bit 1 whenever no byte is being shifted.
- R5: With phase (configuration bit 2) at 0, MISO is captured on the leading SCLK edge and MOSI changes on trailing edges; with phase at 1, MOSI changes on leading edges and MISO is captured on trailing edges.
- R6: When configuration bit 14 is 1, cs_n equals configuration bit 10 (1 = deasserted) and does not move between words; when bit 14 is 0, cs_n is low exactly while a word is being shifted.
- R7: A new word starts only while bit 0 of the enable register (offset 0x14) and configuration bit 0 (master) are both 1; words written meanwhile stay queued.
- R8: Each transmitted word yields exactly one receive word carrying as many bytes as were sent.
- R9: When a word completes with the transmit queue empty while chip select is forced low (bit 14 = 1, bit 10 = 0), tx_underflow pulses for one cycle; it stays low otherwise.
- R10: A receive word completing while the receive queue is full is discarded, rx_overflow pulses for one cycle, and the queued words are left intact.
- R11: After reset cs_n is 1, SCLK is 0, rx_valid is 0 and both event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | 32 | Register write data |
| rx_pop | input | 1 | Remove the head receive word |
| rx_data | output | 32 | Head receive word |
| rx_valid | output | 1 | Receive queue not empty |
| tx_full | output | 1 | Transmit queue full; writes are dropped |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_underflow | output | 1 | Transmit queue ran dry under forced chip select |
| rx_overflow | output | 1 | Receive word dropped |

## Verification
A register write takes effect on the clock edge that samples it; a queued word starts shifting two clocks later and each byte spans sixteen SCLK half periods of 2^x clocks, so a word of n bytes needs 16·n·2^x + 2 clocks before its receive word is visible. The bench's SPI slave model reads the DUT's pins at the falling clock edge, captures MOSI with the value held during the half period before each capture edge and advances MISO after it, so every result is counted in byte units rather than at a predicted edge. Each test waits until the slave has seen the expected byte count and then allows a margin longer than one half period at the slowest divider before reading the receive queue, event counters and pin levels.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int DIV_W      = 3;

  // offsets whose alias carries the byte count
  localparam logic [7:0] OFS_CFG = 8'h00;
  localparam logic [7:0] OFS_EN  = 8'h14;
  localparam logic [7:0] OFS_TX4 = 8'h1C;
  localparam logic [7:0] OFS_TX1 = 8'h80;
  localparam logic [7:0] OFS_TX2 = 8'h84;
  localparam logic [7:0] OFS_TX3 = 8'h88;

  typedef struct packed {
    logic             force_cs;
    logic             cs_lvl;
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             master;
  } cfg_t;

  function automatic cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.master   = w[0];
    c.cpol     = w[1];
    c.cpha     = w[2];
    c.div      = w[5:3];
    c.cs_lvl   = w[10];
    c.force_cs = w[14];
    return c;
  endfunction
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R10: the owner never pushes into a full queue, so nothing is overwritten
  p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_pop_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sfq_sclk_gen.sv
module sfq_sclk_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [3:0]       hp,
  output logic             sclk
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] dcnt_q, dcnt_d, lim;
  logic [3:0]       hp_q, hp_d;

  assign lim  = (CNT_W'(1) << div) - CNT_W'(1);
  assign tick = active && (dcnt_q == lim);
  assign hp   = hp_q;
  assign sclk = cpol ^ (active & hp_q[0]);

  always_comb begin
    dcnt_d = (!active || tick) ? '0 : dcnt_q + 1'b1;
    if (!active)   hp_d = '0;
    else if (tick) hp_d = hp_q + 1'b1;
    else           hp_d = hp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      hp_q   <= '0;
    end else begin
      dcnt_q <= dcnt_d;
      hp_q   <= hp_d;
    end
  end

  // R3: the half-period index moves only on a divider tick
  p_half_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(hp_q));
endmodule

// File: rtl/sfq_word_engine.sv
module sfq_word_engine
  import sfq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        nb_m1,
  input  logic              cpha,
  input  logic              tick,
  input  logic [3:0]        hp,
  input  logic              miso,
  output logic              busy,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] data_q, data_d, acc_q, acc_d, acc_now;
  logic [1:0]        nb_q, nb_d, bidx_q, bidx_d, pad;
  logic [7:0]        rsh_q, rsh_d, cur_byte, new_byte;
  logic              busy_q, busy_d;
  logic              sample, byte_end, last;
  logic [3:0]        hp_adj;

  assign busy     = busy_q;
  assign cur_byte = data_q[8*bidx_q +: 8];
  assign sample   = tick && (hp[0] == cpha);
  assign byte_end = tick && (hp == 4'd15);
  assign last     = (bidx_q == nb_q);
  assign done     = busy_q && byte_end && last;
  assign new_byte = sample ? {rsh_q[6:0], miso} : rsh_q;
  assign hp_adj   = (cpha && hp != 4'd0) ? hp - 4'd1 : (cpha ? 4'd0 : hp);
  assign mosi     = busy_q & cur_byte[3'd7 - hp_adj[3:1]];
  assign pad      = 2'd3 - nb_q;

  always_comb begin
    acc_now = acc_q;
    acc_now[8*bidx_q +: 8] = new_byte;
  end
  assign rx_word = acc_now << {pad, 3'b000};

  always_comb begin
    data_d = data_q;
    nb_d   = nb_q;
    bidx_d = bidx_q;
    acc_d  = acc_q;
    rsh_d  = rsh_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start) begin
        data_d = wdata;
        nb_d   = nb_m1;
        bidx_d = '0;
        acc_d  = '0;
        rsh_d  = '0;
        busy_d = 1'b1;
      end
    end else begin
      rsh_d = new_byte;
      if (byte_end) begin
        acc_d  = acc_now;
        bidx_d = bidx_q + 1'b1;
        if (last) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      nb_q   <= '0;
      bidx_q <= '0;
      acc_q  <= '0;
      rsh_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      data_q <= data_d;
      nb_q   <= nb_d;
      bidx_q <= bidx_d;
      acc_q  <= acc_d;
      rsh_q  <= rsh_d;
      busy_q <= busy_d;
    end
  end

  // R1: a word never shifts more bytes than its alias granted
  p_byte_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bidx_q <= nb_q));
  // R8: a finished word frees the engine on the next cycle
  p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/sfq_engine.sv
module sfq_engine
  import sfq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rx_pop,
  output logic [31:0]       rx_data,
  output logic              rx_valid,
  output logic              tx_full,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              tx_underflow,
  output logic              rx_overflow
);
  localparam int TXE_W = WORD_W + 2;

  logic [1:0]        rst_sync_q;
  logic              rst_i;
  cfg_t              cfg_q, cfg_d;
  logic              en_q, en_d;
  logic              hit_cfg, hit_en, hit_tx;
  logic [1:0]        wr_nb_m1;
  logic              tx_push, tx_empty, rx_full, rx_empty, rx_push;
  logic [TXE_W-1:0]  tx_head;
  logic              run, eng_start, eng_busy, eng_done, eng_mosi;
  logic [WORD_W-1:0] eng_rx;
  logic              tick, gen_sclk;
  logic [3:0]        hp;
  logic              unf_q, unf_d, ovf_q, ovf_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // register and alias decode
  always_comb begin
    hit_cfg  = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
    hit_en   = wr_en && (wr_addr == ADDR_W'(OFS_EN));
    hit_tx   = 1'b0;
    wr_nb_m1 = 2'd3;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(OFS_TX4): begin hit_tx = 1'b1; wr_nb_m1 = 2'd3; end
        ADDR_W'(OFS_TX1): begin hit_tx = 1'b1; wr_nb_m1 = 2'd0; end
        ADDR_W'(OFS_TX2): begin hit_tx = 1'b1; wr_nb_m1 = 2'd1; end
        ADDR_W'(OFS_TX3): begin hit_tx = 1'b1; wr_nb_m1 = 2'd2; end
        default:          hit_tx = 1'b0;
      endcase
    end
    cfg_d = hit_cfg ? unpack_cfg(wr_data) : cfg_q;
    en_d  = hit_en ? wr_data[0] : en_q;
  end
  assign tx_push = hit_tx && !tx_full;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_q <= '{force_cs: 1'b0, cs_lvl: 1'b1, div: '0,
                 cpha: 1'b0, cpol: 1'b0, master: 1'b0};
      en_q  <= 1'b0;
    end else begin
      if (hit_cfg) cfg_q <= cfg_d;
      if (hit_en)  en_q  <= en_d;
    end
  end

  sfq_fifo #(.W(TXE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .push(tx_push), .wdata({wr_nb_m1, wr_data}),
    .pop(eng_start), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  // sequencing
  assign run       = en_q && cfg_q.master;
  assign eng_start = run && !eng_busy && !tx_empty;
  assign rx_push   = eng_done && !rx_full;

  sfq_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_i), .active(eng_busy), .cpol(cfg_q.cpol),
    .div(cfg_q.div), .tick(tick), .hp(hp), .sclk(gen_sclk));

  sfq_word_engine u_word (
    .clk(clk), .rst_n(rst_i), .start(eng_start),
    .wdata(tx_head[WORD_W-1:0]), .nb_m1(tx_head[TXE_W-1 -: 2]),
    .cpha(cfg_q.cpha), .tick(tick), .hp(hp), .miso(miso),
    .busy(eng_busy), .mosi(eng_mosi), .done(eng_done), .rx_word(eng_rx));

  sfq_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .wdata(eng_rx),
    .pop(rx_pop && !rx_empty), .rdata(rx_data), .empty(rx_empty),
    .full(rx_full));

  // events
  always_comb begin
    unf_d = eng_done && tx_empty && cfg_q.force_cs && !cfg_q.cs_lvl;
    ovf_d = eng_done && rx_full;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      unf_q <= unf_d;
      ovf_q <= ovf_d;
    end
  end

  assign rx_valid     = !rx_empty;
  assign sclk         = gen_sclk;
  assign mosi         = eng_mosi;
  assign cs_n         = cfg_q.force_cs ? cfg_q.cs_lvl : !eng_busy;
  assign tx_underflow = unf_q;
  assign rx_overflow  = ovf_q;

  // R4: idle clock level
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_i)
    !eng_busy |-> (sclk == cfg_q.cpol));
  // R6: forced chip select holds across word gaps
  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_q.force_cs && $stable(cfg_q)) |-> $stable(cs_n));
  // R7: a word only begins while the engine is enabled as master
  p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (eng_busy && !$past(eng_busy)) |-> $past(en_q && cfg_q.master));
  // R9: underflow only follows a word finishing with nothing queued
  p_unf_cause_r9: assert property (@(posedge clk) disable iff (!rst_i)
    tx_underflow |-> $past(eng_done && tx_empty));
  // R10: overflow only when the receive queue had no room
  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_i)
    rx_overflow |-> $past(rx_full));
endmodule

// File: tb/sfq_engine_tb.sv
module sfq_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rx_pop = 1'b0;
  logic [31:0] rx_data;
  logic        rx_valid, tx_full, sclk, cs_n, mosi, tx_underflow, rx_overflow;
  logic        miso = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sfq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_full(tx_full), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow));

  // ---------------- SPI slave model ----------------
  logic [7:0] slv_tx [128];
  logic [7:0] slv_rx [128];
  logic       cpol_tb = 1'b0, cpha_tb = 1'b0;
  logic       sclk_prev = 1'b0, mosi_prev = 1'b0, cs_prev = 1'b1;
  logic [7:0] sh = '0;
  int sidx = 0, sbit = 0, cyc = 0, last_rise = 0, rise_period = 0;
  int unf_cnt = 0, ovf_cnt = 0, bad_cs = 0;

  always @(negedge clk) begin
    cyc++;
    if (tx_underflow) unf_cnt++;
    if (rx_overflow)  ovf_cnt++;
    if (cs_n && sclk != cpol_tb) bad_cs++;
    if (sclk != sclk_prev && (!cs_n || !cs_prev)) begin
      if (sclk) begin
        rise_period = cyc - last_rise;
        last_rise = cyc;
      end
      if ((sclk != cpol_tb) != cpha_tb) begin
        sh = {sh[6:0], mosi_prev};
        if (sbit == 7) begin
          slv_rx[sidx % 128] = sh;
          sidx++;
          sbit = 0;
        end else sbit++;
      end
    end
    sclk_prev = sclk;
    mosi_prev = mosi;
    cs_prev   = cs_n;
    miso      = slv_tx[sidx % 128][7 - sbit];
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input bit pol, input bit pha, input int dv,
                         input bit csl, input bit frc);
    logic [31:0] w;
    w = '0;
    w[0] = 1'b1; w[1] = pol; w[2] = pha; w[5:3] = 3'(dv);
    w[10] = csl; w[14] = frc;
    bus_wr(8'h00, w);
    cpol_tb = pol; cpha_tb = pha;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_bytes(input int target);
    int t = 0;
    while (sidx < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (40) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_rx(input int base, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = slv_tx[(base + i) % 128];
    return w << (8 * (4 - n));
  endfunction

  function automatic logic [31:0] got_tx(input int base, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = slv_rx[(base + i) % 128];
    return w;
  endfunction

  task automatic pop_chk(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk({req, " rx_valid"}, 32'(rx_valid), 32'd1);
    chk({req, " rx_data"}, rx_data, exp);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R11 cs_n", 32'(cs_n), 32'd1);
    chk("R11 sclk", 32'(sclk), 32'd0);
    chk("R11 rx_valid", 32'(rx_valid), 32'd0);
    chk("R11 events", {30'd0, tx_underflow, rx_overflow}, 32'd0);
  endtask

  task automatic t_full_word();
    int base, bc, uc;
    set_cfg(0, 0, 0, 1, 0);
    bus_wr(8'h14, 32'd1);
    base = sidx; bc = bad_cs; uc = unf_cnt;
    bus_wr(8'h1C, 32'hA1B2C3D4);
    wait_bytes(base + 4);
    chk("R1 mosi bytes full word", got_tx(base, 4), 32'hA1B2C3D4);
    chk("R1 byte count", 32'(sidx - base), 32'd4);
    chk("R3 period div0", 32'(rise_period), 32'd2);
    chk("R6 cs low while shifting", 32'(bad_cs - bc), 32'd0);
    chk("R9 no underflow unforced", 32'(unf_cnt - uc), 32'd0);
    pop_chk("R2 full rx word", exp_rx(base, 4));
    @(negedge clk);
    chk("R8 single rx word", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_partial();
    int base;
    base = sidx;
    bus_wr(8'h80, 32'hFFFFFF5A);
    bus_wr(8'h88, 32'h00332211);
    bus_wr(8'h84, 32'hEEEE7788);
    wait_bytes(base + 6);
    chk("R1 upper bytes ignored count", 32'(sidx - base), 32'd6);
    chk("R1 one-byte alias", got_tx(base, 1), 32'h5A);
    chk("R1 three-byte alias", got_tx(base + 1, 3), 32'h332211);
    chk("R1 two-byte alias", got_tx(base + 4, 2), 32'h7788);
    pop_chk("R2 one-byte rx packed high", exp_rx(base, 1));
    pop_chk("R2 three-byte rx packed high", exp_rx(base + 1, 3));
    pop_chk("R8 two-byte rx word", exp_rx(base + 4, 2));
    @(negedge clk);
    chk("R8 rx count matches", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_divider(input int dv);
    int base;
    set_cfg(0, 0, dv, 1, 0);
    base = sidx;
    bus_wr(8'h80, 32'h000000C3);
    wait_bytes(base + 1);
    chk($sformatf("R3 period div%0d", dv), 32'(rise_period), 32'(2 << dv));
    pop_chk("R3 data at slow clock", exp_rx(base, 1));
  endtask

  task automatic t_modes();
    int base;
    set_cfg(1, 1, 1, 1, 0);
    chk("R4 idle high with cpol", 32'(sclk), 32'd1);
    base = sidx;
    bus_wr(8'h1C, 32'h0F1E2D3C);
    wait_bytes(base + 4);
    chk("R4 idle high after word", 32'(sclk), 32'd1);
    chk("R5 mode3 mosi", got_tx(base, 4), 32'h0F1E2D3C);
    pop_chk("R5 mode3 miso", exp_rx(base, 4));
    set_cfg(0, 1, 0, 1, 0);
    chk("R4 idle low", 32'(sclk), 32'd0);
    base = sidx;
    bus_wr(8'h84, 32'h0000B44B);
    wait_bytes(base + 2);
    chk("R5 mode1 mosi", got_tx(base, 2), 32'hB44B);
    pop_chk("R5 mode1 miso", exp_rx(base, 2));
  endtask

  task automatic t_forced_cs();
    int base, uc;
    set_cfg(0, 0, 0, 1, 1);
    chk("R6 forced deassert", 32'(cs_n), 32'd1);
    set_cfg(0, 0, 0, 0, 1);
    chk("R6 forced assert idle", 32'(cs_n), 32'd0);
    base = sidx; uc = unf_cnt;
    bus_wr(8'h1C, 32'h11223344);
    bus_wr(8'h1C, 32'h55667788);
    while (sidx < base + 8) begin
      @(negedge clk);
      if (cs_n) begin
        checks++; errors++;
        $display("FAIL R6: actual cs_n=1 expected 0 between words");
      end
    end
    repeat (40) @(negedge clk);
    chk("R6 cs held after words", 32'(cs_n), 32'd0);
    chk("R9 one underflow", 32'(unf_cnt - uc), 32'd1);
    pop_chk("R8 forced word 0", exp_rx(base, 4));
    pop_chk("R8 forced word 1", exp_rx(base + 4, 4));
    set_cfg(0, 0, 0, 1, 1);
    chk("R6 forced release", 32'(cs_n), 32'd1);
    set_cfg(0, 0, 0, 1, 0);
  endtask

  task automatic t_enable();
    int base;
    bus_wr(8'h14, 32'd0);
    base = sidx;
    bus_wr(8'h1C, 32'hCAFE0001);
    repeat (80) @(negedge clk);
    chk("R7 no bytes while disabled", 32'(sidx - base), 32'd0);
    chk("R7 cs idle while disabled", 32'(cs_n), 32'd1);
    bus_wr(8'h14, 32'd1);
    wait_bytes(base + 4);
    chk("R7 queued word kept", got_tx(base, 4), 32'hCAFE0001);
    pop_chk("R7 rx after enable", exp_rx(base, 4));
  endtask

  task automatic t_overflow();
    int base, oc;
    base = sidx; oc = ovf_cnt;
    for (int k = 0; k < 5; k++) bus_wr(8'h1C, 32'h01010101 * (k + 1));
    wait_bytes(base + 20);
    chk("R10 one overflow", 32'(ovf_cnt - oc), 32'd1);
    for (int k = 0; k < 4; k++) pop_chk("R10 kept word", exp_rx(base + 4 * k, 4));
    @(negedge clk);
    chk("R10 dropped word absent", 32'(rx_valid), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 128; k++) slv_tx[k] = 8'((k * 73 + 29) & 255);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_word();
    t_partial();
    t_divider(1);
    t_divider(3);
    t_modes();
    t_forced_cs();
    t_enable();
    t_overflow();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule